// File: doc/BRIEF.md
# Owner-Tagged Rendezvous Unit

This unit joins a producer thread and a consumer thread at one word of a small shared memory. Each word carries an owner tag that names the thread context holding it, along with a flag that says whether that holder is a producer or a consumer. The tag is empty when the word is free. A thread raises a request for a word address. The request is a marked store when the thread produces a value and a marked load when it consumes one. The thread holds the request until the unit acknowledges it.

Whichever side reaches a free word first takes ownership and is parked, meaning its suspend line stays high. The opposite side completes the exchange when it arrives. A consumer arriving at a word held by a producer collects the stored value and releases the producer. A producer arriving at a word held by a consumer writes its value and hands that value straight to the parked consumer. In both cases the word becomes free again. The released thread gets a one-cycle wake pulse. There is no spinning on a status bit. A request that meets an owner of its own role waits until the word is free. When several requests are ready in the same cycle, a fixed-priority arbiter serves one of them.

Top module: `rdv_unit`

## Requirements
- R1: After reset, every ack, suspended, wake and rvalid bit is 0, and every word is free.
- R2: A store to a free word is acknowledged with rvalid low. From that cycle on, the storing thread's suspended bit is 1, and the word records it as a producer owner.
- R3: A load to a word held by a producer is acknowledged with rvalid high and rdata equal to the stored value. In the same cycle, the producer's wake bit pulses and its suspended bit returns to 0.
- R4: After a producer is released by a consumer, the word is free again: the next store to it is acknowledged as a first arrival and suspends.
- R5: A load to a free word is acknowledged with rvalid low. The loading thread's suspended bit becomes 1, and the word records it as a consumer owner.
- R6: A store to a word held by a consumer is acknowledged with rvalid low, and the storing thread is not suspended. In the same cycle, the consumer gets a wake pulse with rvalid high and rdata equal to the stored value, and the word becomes free.
- R7: At most one request is acknowledged per cycle. Among ready requests, the lowest thread index wins, and the others stay pending for later cycles.
- R8: A request whose role matches the current owner's role (store on a producer-held word, load on a consumer-held word) is not acknowledged while the word stays held. It is served once the word is free.
- R9: A wake is a single-cycle pulse, goes only to a thread that was suspended in the previous cycle, and at most one thread is woken per cycle.
- R10: Ownership is tracked per word: holding one address does not block requests to other addresses.
- R11: All outputs are registered and change one clock edge after the request is sampled. A parked thread's requests are not served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NT | Per-thread request, held until ack |
| req_store | input | NT | 1 = producer store, 0 = consumer load |
| req_addr | input | NT*AW | Per-thread word address, thread t at bits [t*AW +: AW] |
| req_wdata | input | NT*DW | Per-thread store value, thread t at bits [t*DW +: DW] |
| ack | output | NT | One-cycle acknowledge of the served request |
| suspended | output | NT | Thread is parked as a word owner |
| wake | output | NT | One-cycle release pulse to a parked thread |
| rvalid | output | NT | Read data valid for this thread this cycle |
| rdata | output | NT*DW | Per-thread read data, thread t at bits [t*DW +: DW] |

## Verification
The checker tests the cycle-level invariants on every cycle:
- at most one acknowledge and at most one wake per cycle;
- a suspend bit rises only together with an acknowledge and falls only together with a wake;
- wakes go only to parked threads and never repeat in back-to-back cycles;
- read data is flagged only for an acknowledged or woken thread;
- a parked thread is never acknowledged.

Other behaviour needs the bench's scenarios. These cover the value carried across the rendezvous in both arrival orders, the word becoming free again after release, a same-role request waiting and then being served, and the priority order among simultaneous requests to different words.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

   // outcome of the single request served in a cycle
   typedef enum logic [2:0] {
      ACT_IDLE    = 3'd0,
      ACT_PARK_P  = 3'd1,  // producer claims a free word
      ACT_PARK_C  = 3'd2,  // consumer claims a free word
      ACT_COLLECT = 3'd3,  // consumer meets parked producer
      ACT_HANDOFF = 3'd4   // producer meets parked consumer
   } act_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rdv_prio_arb.sv
module rdv_prio_arb #(
   parameter int N     = 4,
   parameter int STYLE = 0,
   localparam int IW   = rdv_pkg::idx_width(N)
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);

   generate
      if (STYLE == 0) begin : g_scan
         always_comb begin
            gnt = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) begin
                  gnt    = '0;
                  gnt[i] = 1'b1;
               end
            end
         end
      end else begin : g_twos
         assign gnt = req & (~req + N'(1));
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt[i]) idx = IW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/rdv_word_store.sv
module rdv_word_store #(
   parameter int NT    = 4,
   parameter int DEPTH = 8,
   parameter int DW    = 16,
   localparam int AW   = rdv_pkg::idx_width(DEPTH),
   localparam int IW   = rdv_pkg::idx_width(NT)
) (
   input  logic             clk,
   input  logic             rst_n,
   // per-thread owner lookup
   input  logic [AW-1:0]    look_addr [NT],
   output logic [NT-1:0]    look_held,
   output logic [NT-1:0]    look_cons,
   output logic [IW-1:0]    look_owner [NT],
   // data read for the served request
   input  logic [AW-1:0]    sel_addr,
   output logic [DW-1:0]    sel_data,
   // single update port
   input  logic             tag_we,
   input  logic             tag_held,
   input  logic             tag_cons,
   input  logic [IW-1:0]    tag_owner,
   input  logic             data_we,
   input  logic [DW-1:0]    data_in
);

   logic          held_q  [DEPTH];
   logic          cons_q  [DEPTH];
   logic [IW-1:0] owner_q [DEPTH];
   logic [DW-1:0] mem_q   [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < DEPTH; w++) begin
            held_q[w]  <= 1'b0;
            cons_q[w]  <= 1'b0;
            owner_q[w] <= '0;
            mem_q[w]   <= '0;
         end
      end else begin
         if (tag_we) begin
            held_q[sel_addr]  <= tag_held;
            cons_q[sel_addr]  <= tag_cons;
            owner_q[sel_addr] <= tag_owner;
         end
         if (data_we) mem_q[sel_addr] <= data_in;
      end
   end

   generate
      for (genvar t = 0; t < NT; t++) begin : g_look
         assign look_held[t]  = held_q[look_addr[t]];
         assign look_cons[t]  = cons_q[look_addr[t]];
         assign look_owner[t] = owner_q[look_addr[t]];
      end
   endgenerate

   assign sel_data = mem_q[sel_addr];

endmodule

// File: rtl/rdv_req_screen.sv
module rdv_req_screen (
   input  logic valid,
   input  logic is_store,
   input  logic parked,
   input  logic held,
   input  logic held_by_cons,
   output logic eligible
);

   // same role as current owner: wait for the word to free up
   logic same_role;
   assign same_role = held & (held_by_cons == ~is_store);
   assign eligible  = valid & ~parked & ~same_role;

endmodule

// File: rtl/rdv_unit.sv
module rdv_unit #(
   parameter int NT        = 4,
   parameter int DEPTH     = 8,
   parameter int DW        = 16,
   parameter int ARB_STYLE = 0,
   localparam int AW       = rdv_pkg::idx_width(DEPTH),
   localparam int IW       = rdv_pkg::idx_width(NT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NT-1:0]    req_valid,
   input  logic [NT-1:0]    req_store,
   input  logic [NT*AW-1:0] req_addr,
   input  logic [NT*DW-1:0] req_wdata,
   output logic [NT-1:0]    ack,
   output logic [NT-1:0]    suspended,
   output logic [NT-1:0]    wake,
   output logic [NT-1:0]    rvalid,
   output logic [NT*DW-1:0] rdata
);
   import rdv_pkg::*;

   generate
      if (NT < 2) begin : g_bad_nt
         $error("rdv_unit: NT must be at least 2");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rdv_unit: DEPTH must be a power of two >= 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("rdv_unit: DW must be positive");
      end
      if (ARB_STYLE != 0 && ARB_STYLE != 1) begin : g_bad_arb
         $error("rdv_unit: ARB_STYLE must be 0 or 1");
      end
   endgenerate

   logic [AW-1:0] addr_a  [NT];
   logic [DW-1:0] wdata_a [NT];
   logic [IW-1:0] owner_a [NT];
   logic [DW-1:0] rdata_q [NT];
   logic [NT-1:0] held_v, cons_v, elig, gnt;
   logic [IW-1:0] g;
   logic          any;

   generate
      for (genvar t = 0; t < NT; t++) begin : g_thr
         assign addr_a[t]  = req_addr[t*AW +: AW];
         assign wdata_a[t] = req_wdata[t*DW +: DW];
         assign rdata[t*DW +: DW] = rdata_q[t];

         rdv_req_screen u_screen (
            .valid        (req_valid[t]),
            .is_store     (req_store[t]),
            .parked       (suspended[t]),
            .held         (held_v[t]),
            .held_by_cons (cons_v[t]),
            .eligible     (elig[t])
         );
      end
   endgenerate

   rdv_prio_arb #(.N(NT), .STYLE(ARB_STYLE)) u_arb (
      .req (elig),
      .gnt (gnt),
      .idx (g),
      .any (any)
   );

   // served request
   logic          s_store, s_held, s_cons;
   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_wdata, s_mem;
   logic [IW-1:0] s_owner;
   act_e          act;

   assign s_store = req_store[g];
   assign s_held  = held_v[g];
   assign s_cons  = cons_v[g];
   assign s_addr  = addr_a[g];
   assign s_wdata = wdata_a[g];
   assign s_owner = owner_a[g];

   always_comb begin
      if (!any)         act = ACT_IDLE;
      else if (!s_held) act = s_store ? ACT_PARK_P : ACT_PARK_C;
      else if (s_store) act = ACT_HANDOFF;
      else              act = ACT_COLLECT;
   end

   logic tag_held, tag_cons, data_we;
   assign tag_held = (act == ACT_PARK_P) || (act == ACT_PARK_C);
   assign tag_cons = (act == ACT_PARK_C);
   assign data_we  = (act == ACT_PARK_P) || (act == ACT_HANDOFF);

   rdv_word_store #(.NT(NT), .DEPTH(DEPTH), .DW(DW)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .look_addr  (addr_a),
      .look_held  (held_v),
      .look_cons  (cons_v),
      .look_owner (owner_a),
      .sel_addr   (s_addr),
      .sel_data   (s_mem),
      .tag_we     (any),
      .tag_held   (tag_held),
      .tag_cons   (tag_cons),
      .tag_owner  (g),
      .data_we    (data_we),
      .data_in    (s_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack       <= '0;
         suspended <= '0;
         wake      <= '0;
         rvalid    <= '0;
         for (int t = 0; t < NT; t++) rdata_q[t] <= '0;
      end else begin
         ack    <= gnt;
         wake   <= '0;
         rvalid <= '0;
         unique case (act)
            ACT_PARK_P, ACT_PARK_C: suspended[g] <= 1'b1;
            ACT_COLLECT: begin
               suspended[s_owner] <= 1'b0;
               wake[s_owner]      <= 1'b1;
               rvalid[g]          <= 1'b1;
               rdata_q[g]         <= s_mem;
            end
            ACT_HANDOFF: begin
               suspended[s_owner] <= 1'b0;
               wake[s_owner]      <= 1'b1;
               rvalid[s_owner]    <= 1'b1;
               rdata_q[s_owner]   <= s_wdata;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/rdv_unit_chk.sv
module rdv_unit_chk #(
   parameter int NT = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NT-1:0] ack,
   input logic [NT-1:0] suspended,
   input logic [NT-1:0] wake,
   input logic [NT-1:0] rvalid
);

   // R7
   one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack));

   // R9
   one_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wake));

   generate
      for (genvar t = 0; t < NT; t++) begin : g_t
         // R9
         wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wake[t] |=> !wake[t]);
         // R9
         wake_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wake[t] |-> ($past(suspended[t]) && !suspended[t]));
         // R2
         park_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(suspended[t]) |-> ack[t]);
         // R3
         release_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(suspended[t]) |-> wake[t]);
         // R6
         rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rvalid[t] |-> (ack[t] || wake[t]));
         // R11
         parked_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ack[t] |-> !$past(suspended[t]));
      end
   endgenerate

endmodule

bind rdv_unit rdv_unit_chk #(.NT(NT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack       (ack),
   .suspended (suspended),
   .wake      (wake),
   .rvalid    (rvalid)
);

// File: tb/rdv_unit_test.sv
`timescale 1ns/1ps
module rdv_unit_test;
   localparam int NT = 4;
   localparam int DEPTH = 8;
   localparam int DW = 16;
   localparam int AW = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NT-1:0]    req_valid = '0;
   logic [NT-1:0]    req_store = '0;
   logic [NT*AW-1:0] req_addr = '0;
   logic [NT*DW-1:0] req_wdata = '0;
   logic [NT-1:0]    ack, suspended, wake, rvalid;
   logic [NT*DW-1:0] rdata;

   int checks = 0;
   int errors = 0;

   typedef struct {
      int          tid;
      bit          is_wake;
      bit          rv;
      logic [15:0] data;
      bit          susp;
      string       tag;
   } exp_t;

   exp_t q[$];

   rdv_unit #(.NT(NT), .DEPTH(DEPTH), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack),
      .suspended(suspended), .wake(wake), .rvalid(rvalid), .rdata(rdata)
   );

   always #2 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic expect_ev(input int tid, input bit w, input bit rv,
                            input logic [15:0] d, input bit s, input string tag);
      exp_t e;
      e.tid = tid; e.is_wake = w; e.rv = rv; e.data = d; e.susp = s; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic issue(input int t, input bit st, input int a, input int d);
      req_store[t] = st;
      req_addr[t*AW +: AW] = a[AW-1:0];
      req_wdata[t*DW +: DW] = d[DW-1:0];
      req_valid[t] = 1'b1;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // monitor: pops expected events in cycle order, ascending thread within a cycle
   always @(negedge clk) begin
      if (rst_n) begin
         for (int t = 0; t < NT; t++) begin
            if (ack[t] || wake[t]) begin
               checks++;
               if (q.size() == 0) begin
                  errors++;
                  $display("FAIL R9 unexpected event thread %0d: actual ack=%0b wake=%0b expected none",
                           t, ack[t], wake[t]);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  if (e.tid != t || e.is_wake != wake[t] || e.rv != rvalid[t] ||
                      (e.rv && rdata[t*DW +: DW] !== e.data) || e.susp != suspended[t]) begin
                     errors++;
                     $display("FAIL %s: actual tid=%0d wake=%0b rv=%0b data=%0h susp=%0b expected tid=%0d wake=%0b rv=%0b data=%0h susp=%0b",
                              e.tag, t, wake[t], rvalid[t], rdata[t*DW +: DW], suspended[t],
                              e.tid, e.is_wake, e.rv, e.data, e.susp);
                  end
               end
            end
         end
         for (int t = 0; t < NT; t++) if (ack[t]) req_valid[t] = 1'b0;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ack", 32'(ack), 0);
      check("R1 suspended", 32'(suspended), 0);
      check("R1 wake", 32'(wake), 0);
      check("R1 rvalid", 32'(rvalid), 0);

      // R2 producer first, R3 consumer collects
      expect_ev(1, 0, 0, 0, 1, "R2 producer park");
      issue(1, 1, 2, 16'hA5A5);
      drain();
      check("R2 producer stays suspended", 32'(suspended[1]), 1);
      expect_ev(1, 1, 0, 0, 0, "R3 producer wake");
      expect_ev(2, 0, 1, 16'hA5A5, 0, "R3 consumer data");
      issue(2, 0, 2, 0);
      drain();
      check("R9 wake is a pulse", 32'(wake), 0);

      // R4 word free again
      expect_ev(0, 0, 0, 0, 1, "R4 first arrival again");
      issue(0, 1, 2, 16'h1111);
      drain();
      expect_ev(0, 1, 0, 0, 0, "R4 producer wake");
      expect_ev(3, 0, 1, 16'h1111, 0, "R4 consumer data");
      issue(3, 0, 2, 0);
      drain();

      // R5 consumer first, R6 producer hands off
      expect_ev(2, 0, 0, 0, 1, "R5 consumer park");
      issue(2, 0, 5, 0);
      drain();
      check("R5 consumer no data", 32'(rvalid[2]), 0);
      expect_ev(0, 0, 0, 0, 0, "R6 producer not parked");
      expect_ev(2, 1, 1, 16'hBEEF, 0, "R6 consumer wake data");
      issue(0, 1, 5, 16'hBEEF);
      drain();
      // R6 word free: a fresh consumer parks again
      expect_ev(1, 0, 0, 0, 1, "R6 word freed");
      issue(1, 0, 5, 0);
      drain();
      expect_ev(1, 1, 1, 16'h0F0F, 0, "R6 second handoff");
      expect_ev(3, 0, 0, 0, 0, "R6 producer ack");
      issue(3, 1, 5, 16'h0F0F);
      drain();

      // R8 same-role stall
      expect_ev(1, 0, 0, 0, 1, "R8 first producer park");
      issue(1, 1, 3, 16'h0003);
      drain();
      issue(0, 1, 3, 16'h0033);
      repeat (5) @(negedge clk);
      check("R8 second producer stalled ack", 32'(ack[0]), 0);
      check("R8 second producer not parked", 32'(suspended[0]), 0);
      expect_ev(1, 1, 0, 0, 0, "R8 first producer wake");
      expect_ev(2, 0, 1, 16'h0003, 0, "R8 consumer gets first value");
      expect_ev(0, 0, 0, 0, 1, "R8 stalled producer served");
      issue(2, 0, 3, 0);
      drain();
      expect_ev(0, 1, 0, 0, 0, "R8 second producer wake");
      expect_ev(3, 0, 1, 16'h0033, 0, "R8 second value");
      issue(3, 0, 3, 0);
      drain();

      // R7 priority, R10 per-word ownership
      expect_ev(1, 0, 0, 0, 1, "R7 lowest first");
      expect_ev(2, 0, 0, 0, 1, "R7 second");
      expect_ev(3, 0, 0, 0, 1, "R7 third");
      issue(3, 1, 6, 16'h6666);
      issue(1, 1, 7, 16'h7777);
      issue(2, 1, 0, 16'h0A0A);
      drain();
      check("R10 three words held", 32'(suspended), 32'hE);
      expect_ev(0, 0, 1, 16'h6666, 0, "R10 word6 data");
      expect_ev(3, 1, 0, 0, 0, "R10 word6 wake");
      issue(0, 0, 6, 0);
      drain();
      expect_ev(0, 0, 1, 16'h7777, 0, "R10 word7 data");
      expect_ev(1, 1, 0, 0, 0, "R10 word7 wake");
      issue(0, 0, 7, 0);
      drain();
      expect_ev(0, 0, 1, 16'h0A0A, 0, "R10 word0 data");
      expect_ev(2, 1, 0, 0, 0, "R10 word0 wake");
      issue(0, 0, 0, 0);
      drain();

      check("R11 all released", 32'(suspended), 0);
      check("R7 no pending expectations", 32'(q.size()), 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule